// File: doc/BRIEF.md
# Dual-Context Page Translation Table

This block turns an 18-bit virtual word address into a physical word address for a processor that keeps separate address spaces for supervisor and user code. It holds one directly indexed table per privilege level, with one entry per 512-word page. When paging is switched off, both contexts fall through to a fixed identity mapping. Each request names the access type (read or write) and whether the current or the previous context applies. One cycle later the block answers with one of three outcomes: a translated physical address, a hit in the low register window (which never reaches memory), or a refill request. A refill request tells the page-walk engine which table and which access type need service.

The walk engine writes the entries it finds through a dedicated fill port. The entry encoding folds state into its value. An all-zero word means nothing is mapped. A word whose top bit is clear but which is otherwise non-zero maps the page read-only. A word with the top bit set maps the page read-write. A per-page invalidate clears a page in both tables at once, and in double-size page mode it clears the even/odd pair. A flush, which is issued whenever a table base register is reloaded, empties both tables in a single cycle.

Top module: `dual_ctx_xlate`

## Requirements
- R1: During and straight after reset, `rsp_valid` and `fill_fault` are low and every entry of both tables reads as invalid.
- R2: A request accepted on one clock edge produces exactly one response with `rsp_valid` high on the next edge. No response appears without a request.
- R3: A virtual address below `REG_WIN` (default 16) answers `rsp_kind` = 1 (register window). This holds with paging on or off and whatever the table contents.
- R4: With paging off, any address at or above `REG_WIN` answers `rsp_kind` = 0, with `rsp_pa` equal to the zero-extended virtual address. This applies to reads and writes in both contexts.
- R5: Entry layout is as follows. Bit `ENT_W-1` is the writable flag, bit `ENT_W-2` is the valid flag, and bits `PPN_W-1:0` hold the physical page. A completed translation gives `rsp_pa` = {page field, virtual address bits 8:0}.
- R6: A read whose entry is all zero, or a write whose entry has bit `ENT_W-1` clear, answers `rsp_kind` = 2 (refill). On a refill, `rsp_write` repeats the access type and `rsp_user` is 1 when the user table was consulted.
- R7: With paging on and `user_mode` high, both contexts use the user table. With `user_mode` low, the current context uses the supervisor table. The previous context then uses the user table only when `prev_user` is high.
- R8: A fill writes `fill_entry` into the table chosen by `fill_user` (1 = user) at `fill_vpn`. A fill of all zeros leaves that entry invalid and raises `fill_fault` on the next edge. A non-zero fill leaves `fill_fault` low.
- R9: An invalidate clears the entry at `inv_vpn` in both tables. With `dbl_page` high, it clears both the even and the odd entry of that page pair in both tables, and other entries are kept.
- R10: A flush clears every entry of both tables in one cycle. A request on the following edge already sees the empty tables.
- R11: A lookup sees the table contents from before any fill, invalidate or flush issued in the same cycle. When a flush or invalidate hits the same entry as a fill in that cycle, the entry ends up invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| paging_en | input | 1 | Translation enabled; low selects the identity mapping |
| user_mode | input | 1 | Processor runs in user mode |
| prev_user | input | 1 | In supervisor mode, previous context refers to user space |
| dbl_page | input | 1 | Invalidate clears the even/odd entry pair |
| req_valid | input | 1 | Translation request |
| req_write | input | 1 | Request is a write |
| req_prev | input | 1 | Request uses the previous context |
| req_va | input | VA_W | Virtual word address |
| fill_valid | input | 1 | Fill port write strobe |
| fill_user | input | 1 | Fill targets the user table (else supervisor) |
| fill_vpn | input | VA_W-OFS_W | Page index written by the fill |
| fill_entry | input | PA_W-OFS_W+2 | New entry word |
| inv_valid | input | 1 | Invalidate one page (or pair) |
| inv_vpn | input | VA_W-OFS_W | Page index to invalidate |
| flush | input | 1 | Clear both tables |
| rsp_valid | output | 1 | Response strobe |
| rsp_kind | output | 2 | 0 translated, 1 register window, 2 refill |
| rsp_write | output | 1 | Access type of the answered request |
| rsp_user | output | 1 | The user table was consulted |
| rsp_pa | output | PA_W | Physical address |
| fill_fault | output | 1 | Previous fill carried an all-zero entry |

## Verification
The bench uses the defaults: 18-bit virtual addresses, 512-word pages and a 20-bit physical address. Page fields are therefore 11 bits, two bits wider than the page index. The bench uses a page value above 0x1FF, so it can tell a real table hit from an identity pass-through. Because the page index is 9 bits wide, pair invalidation and single-entry invalidation can be told apart on neighbouring even/odd pages. The default register window of 16 lets the bench probe both sides of the window boundary.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [1:0] {
    KIND_DONE    = 2'd0,
    KIND_REGFILE = 2'd1,
    KIND_REFILL  = 2'd2
  } xlate_kind_e;

  typedef enum logic [1:0] {
    TBL_SUP   = 2'd0,
    TBL_USR   = 2'd1,
    TBL_IDENT = 2'd2
  } tbl_sel_e;

endpackage

// File: rtl/xlate_ctx_sel.sv
module xlate_ctx_sel
  import xlate_pkg::*;
(
  input  logic     paging_en,
  input  logic     user_mode,
  input  logic     prev_user,
  input  logic     req_prev,
  output tbl_sel_e sel
);

  always_comb begin
    if (!paging_en)                   sel = TBL_IDENT;
    else if (user_mode)               sel = TBL_USR;
    else if (req_prev && prev_user)   sel = TBL_USR;
    else                              sel = TBL_SUP;
  end

endmodule

// File: rtl/xlate_bank.sv
module xlate_bank #(
  parameter int VPN_W = 9,
  parameter int ENT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] rd_idx,
  output logic [ENT_W-1:0] rd_ent,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_idx,
  input  logic [ENT_W-1:0] fill_ent,
  input  logic             inv_en,
  input  logic [VPN_W-1:0] inv_idx,
  input  logic             inv_pair,
  input  logic             flush
);

  localparam int DEPTH = 1 << VPN_W;

  logic [DEPTH-1:0] vld_q, vld_d;
  logic [ENT_W-1:0] word_q [DEPTH];

  // next state of the valid vector: flush wins, invalidate beats fill
  always_comb begin
    vld_d = vld_q;
    if (flush) begin
      vld_d = '0;
    end else begin
      if (fill_en) vld_d[fill_idx] = |fill_ent;
      if (inv_en) begin
        if (inv_pair) begin
          vld_d[{inv_idx[VPN_W-1:1], 1'b0}] = 1'b0;
          vld_d[{inv_idx[VPN_W-1:1], 1'b1}] = 1'b0;
        end else begin
          vld_d[inv_idx] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // entry words carry no reset; the valid vector gates them
  always_ff @(posedge clk) begin
    if (fill_en) word_q[fill_idx] <= fill_ent;
  end

  assign rd_ent = vld_q[rd_idx] ? word_q[rd_idx] : '0;

endmodule

// File: rtl/dual_ctx_xlate.sv
module dual_ctx_xlate
  import xlate_pkg::*;
#(
  parameter int VA_W    = 18,
  parameter int OFS_W   = 9,
  parameter int PA_W    = 20,
  parameter int REG_WIN = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          paging_en,
  input  logic                          user_mode,
  input  logic                          prev_user,
  input  logic                          dbl_page,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic                          req_prev,
  input  logic [VA_W-1:0]               req_va,
  input  logic                          fill_valid,
  input  logic                          fill_user,
  input  logic [VA_W-OFS_W-1:0]         fill_vpn,
  input  logic [PA_W-OFS_W+1:0]         fill_entry,
  input  logic                          inv_valid,
  input  logic [VA_W-OFS_W-1:0]         inv_vpn,
  input  logic                          flush,
  output logic                          rsp_valid,
  output logic [1:0]                    rsp_kind,
  output logic                          rsp_write,
  output logic                          rsp_user,
  output logic [PA_W-1:0]               rsp_pa,
  output logic                          fill_fault
);

  localparam int VPN_W = VA_W - OFS_W;
  localparam int PPN_W = PA_W - OFS_W;
  localparam int ENT_W = PPN_W + 2;
  localparam int NBANK = 2;

  logic [VPN_W-1:0] vpn;
  logic [OFS_W-1:0] ofs;
  tbl_sel_e         sel;
  logic [ENT_W-1:0] bank_ent [NBANK];
  logic [ENT_W-1:0] ent;
  logic             in_win, miss;

  xlate_kind_e      kind_d, kind_q;
  logic [PA_W-1:0]  pa_d, pa_q;
  logic             user_d, user_q, write_q;
  logic             valid_q, fault_q;

  assign vpn = req_va[VA_W-1:OFS_W];
  assign ofs = req_va[OFS_W-1:0];

  xlate_ctx_sel u_sel (
    .paging_en (paging_en),
    .user_mode (user_mode),
    .prev_user (prev_user),
    .req_prev  (req_prev),
    .sel       (sel)
  );

  // bank 0 serves supervisor space, bank 1 user space
  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    xlate_bank #(.VPN_W(VPN_W), .ENT_W(ENT_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (vpn),
      .rd_ent   (bank_ent[g]),
      .fill_en  (fill_valid && (fill_user == g[0])),
      .fill_idx (fill_vpn),
      .fill_ent (fill_entry),
      .inv_en   (inv_valid),
      .inv_idx  (inv_vpn),
      .inv_pair (dbl_page),
      .flush    (flush)
    );
  end

  always_comb begin
    unique case (sel)
      TBL_USR: ent = bank_ent[1];
      TBL_SUP: ent = bank_ent[0];
      default: ent = {1'b1, 1'b1, PPN_W'(vpn)};
    endcase
    in_win = (req_va < VA_W'(REG_WIN));
    miss   = req_write ? !ent[ENT_W-1] : (ent == '0);
    user_d = (sel == TBL_USR);
    if (in_win) begin
      kind_d = KIND_REGFILE;
      pa_d   = PA_W'(req_va);
    end else if (miss) begin
      kind_d = KIND_REFILL;
      pa_d   = '0;
    end else begin
      kind_d = KIND_DONE;
      pa_d   = {ent[PPN_W-1:0], ofs};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      valid_q <= req_valid;
      fault_q <= fill_valid && (fill_entry == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      kind_q  <= kind_d;
      pa_q    <= pa_d;
      user_q  <= user_d;
      write_q <= req_write;
    end
  end

  assign rsp_valid  = valid_q;
  assign rsp_kind   = kind_q;
  assign rsp_pa     = pa_q;
  assign rsp_user   = user_q;
  assign rsp_write  = write_q;
  assign fill_fault = fault_q;

endmodule

// File: rtl/xlate_chk.sv
module xlate_chk #(
  parameter int VA_W    = 18,
  parameter int PA_W    = 20,
  parameter int REG_WIN = 16,
  parameter int ENT_W   = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             paging_en,
  input logic             req_valid,
  input logic [VA_W-1:0]  req_va,
  input logic             fill_valid,
  input logic [ENT_W-1:0] fill_entry,
  input logic             flush,
  input logic             rsp_valid,
  input logic [1:0]       rsp_kind,
  input logic [PA_W-1:0]  rsp_pa,
  input logic             fill_fault
);

  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_reg_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_va < VA_W'(REG_WIN)) |=> rsp_kind == 2'd1);

  assert_identity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !paging_en && (req_va >= VA_W'(REG_WIN))
    |=> (rsp_kind == 2'd0) && (rsp_pa == PA_W'($past(req_va))));

  assert_zero_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && (fill_entry == '0) |=> fill_fault);

  assert_good_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && (fill_entry != '0) |=> !fill_fault);

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) && req_valid && paging_en && (req_va >= VA_W'(REG_WIN))
    |=> rsp_kind == 2'd2);

endmodule

bind dual_ctx_xlate xlate_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .REG_WIN(REG_WIN), .ENT_W(ENT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .paging_en  (paging_en),
  .req_valid  (req_valid),
  .req_va     (req_va),
  .fill_valid (fill_valid),
  .fill_entry (fill_entry),
  .flush      (flush),
  .rsp_valid  (rsp_valid),
  .rsp_kind   (rsp_kind),
  .rsp_pa     (rsp_pa),
  .fill_fault (fill_fault)
);

// File: tb/dual_ctx_xlate_test.sv
`timescale 1ns/1ps
module dual_ctx_xlate_test;

  localparam int VA_W = 18;
  localparam int PA_W = 20;
  localparam int VPN_W = 9;
  localparam int ENT_W = 13;

  logic clk = 1'b0;
  logic rst_n;
  logic paging_en, user_mode, prev_user, dbl_page;
  logic req_valid, req_write, req_prev;
  logic [VA_W-1:0] req_va;
  logic fill_valid, fill_user;
  logic [VPN_W-1:0] fill_vpn;
  logic [ENT_W-1:0] fill_entry;
  logic inv_valid;
  logic [VPN_W-1:0] inv_vpn;
  logic flush;
  logic rsp_valid, rsp_write, rsp_user, fill_fault;
  logic [1:0] rsp_kind;
  logic [PA_W-1:0] rsp_pa;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic [1:0]      kind;
    logic [PA_W-1:0] pa;
    logic            wr;
    logic            usr;
    string           tag;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  dual_ctx_xlate uut (
    .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .user_mode(user_mode),
    .prev_user(prev_user), .dbl_page(dbl_page), .req_valid(req_valid),
    .req_write(req_write), .req_prev(req_prev), .req_va(req_va),
    .fill_valid(fill_valid), .fill_user(fill_user), .fill_vpn(fill_vpn),
    .fill_entry(fill_entry), .inv_valid(inv_valid), .inv_vpn(inv_vpn),
    .flush(flush), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .rsp_write(rsp_write), .rsp_user(rsp_user), .rsp_pa(rsp_pa),
    .fill_fault(fill_fault)
  );

  function automatic logic [VA_W-1:0] va(input int pg, input int off);
    return VA_W'((pg << 9) | off);
  endfunction

  function automatic logic [PA_W-1:0] pa(input int pg, input int off);
    return PA_W'((pg << 9) | off);
  endfunction

  // entry word: writable flag, valid flag, 11-bit page
  function automatic logic [ENT_W-1:0] ent(input logic w, input int pg);
    return {w, 1'b1, 11'(pg)};
  endfunction

  task automatic fail_line(input string tag, input string what);
    fails++;
    $display("FAIL %s %s", tag, what);
  endtask

  // monitor: pop one expectation per response cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (!rsp_valid)
          fail_line(e.tag, $sformatf("rsp_valid actual=0 expected=1"));
        else if (rsp_kind != e.kind)
          fail_line(e.tag, $sformatf("rsp_kind actual=%0d expected=%0d", rsp_kind, e.kind));
        else if (e.kind == 2'd0 && rsp_pa != e.pa)
          fail_line(e.tag, $sformatf("rsp_pa actual=%h expected=%h", rsp_pa, e.pa));
        else if (e.kind == 2'd2 && (rsp_write != e.wr || rsp_user != e.usr))
          fail_line(e.tag, $sformatf("write/user actual=%0d/%0d expected=%0d/%0d",
                                     rsp_write, rsp_user, e.wr, e.usr));
      end else if (rsp_valid) begin
        checks++;
        fail_line("R2", "rsp_valid actual=1 expected=0");
      end
    end
  end

  task automatic send(input logic w, input logic p, input logic [VA_W-1:0] a,
                      input logic [1:0] k, input logic [PA_W-1:0] xpa,
                      input logic u, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_prev = p; req_va = a;
    @(posedge clk);
    e.kind = k; e.pa = xpa; e.wr = w; e.usr = u; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic fill(input logic u, input int pg, input logic [ENT_W-1:0] d,
                      input logic xfault);
    @(negedge clk);
    fill_valid = 1'b1; fill_user = u; fill_vpn = VPN_W'(pg); fill_entry = d;
    @(negedge clk);
    fill_valid = 1'b0;
    checks++;
    if (fill_fault != xfault)
      fail_line("R8", $sformatf("fill_fault actual=%0d expected=%0d", fill_fault, xfault));
  endtask

  task automatic inval(input int pg, input logic pair);
    @(negedge clk);
    inv_valid = 1'b1; inv_vpn = VPN_W'(pg); dbl_page = pair;
    @(negedge clk);
    inv_valid = 1'b0; dbl_page = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    paging_en = 0; user_mode = 0; prev_user = 0; dbl_page = 0;
    req_valid = 0; req_write = 0; req_prev = 0; req_va = '0;
    fill_valid = 0; fill_user = 0; fill_vpn = '0; fill_entry = '0;
    inv_valid = 0; inv_vpn = '0; flush = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || fill_fault !== 1'b0)
      fail_line("R1", $sformatf("in reset actual=%0d/%0d expected=0/0", rsp_valid, fill_fault));
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || fill_fault !== 1'b0)
      fail_line("R1", $sformatf("after reset actual=%0d/%0d expected=0/0", rsp_valid, fill_fault));

    // R4 identity with paging off
    send(0, 0, 18'h12345, 2'd0, 20'h12345, 0, "R4");
    send(1, 1, 18'h3FFFF, 2'd0, 20'h3FFFF, 0, "R4");
    send(1, 0, 18'h00010, 2'd0, 20'h00010, 0, "R4");
    // R3 register window, both paging states
    send(1, 0, 18'h0000F, 2'd1, 20'h0000F, 0, "R3");
    paging_en = 1;
    send(0, 0, 18'h00005, 2'd1, 20'h00005, 0, "R3");
    // R1 tables empty after reset
    send(0, 0, va(2, 'hAB), 2'd2, '0, 0, "R1");
    send(0, 0, va(300, 1), 2'd2, '0, 0, "R1");

    // R5/R6 read-only then read-write supervisor entry
    fill(0, 2, ent(0, 'h155), 0);
    send(0, 0, va(2, 'hAB), 2'd0, pa('h155, 'hAB), 0, "R5");
    send(1, 0, va(2, 'hAB), 2'd2, '0, 0, "R6");
    fill(0, 2, ent(1, 'h7FF), 0);
    send(1, 0, va(2, 'hAB), 2'd0, pa('h7FF, 'hAB), 0, "R5");

    // R7 context selection
    user_mode = 1;
    send(0, 0, va(2, 'hAB), 2'd2, '0, 1, "R7");
    send(1, 1, va(2, 'hAB), 2'd2, '0, 1, "R7");
    user_mode = 0;
    send(0, 1, va(2, 'hAB), 2'd0, pa('h7FF, 'hAB), 0, "R7");
    prev_user = 1;
    send(1, 1, va(2, 'hAB), 2'd2, '0, 1, "R7");
    send(0, 0, va(2, 'h1FF), 2'd0, pa('h7FF, 'h1FF), 0, "R7");
    prev_user = 0;

    // R8 zero fill faults and leaves the entry invalid
    fill(1, 3, '0, 1);
    user_mode = 1;
    send(0, 0, va(3, 7), 2'd2, '0, 1, "R8");
    fill(1, 3, ent(0, 'h033), 0);
    send(0, 0, va(3, 7), 2'd0, pa('h033, 7), 0, "R8");
    send(1, 0, va(3, 7), 2'd2, '0, 1, "R6");

    // R9 invalidate single entry, then pair
    fill(1, 4, ent(1, 'h010), 0);
    fill(1, 5, ent(1, 'h011), 0);
    fill(0, 4, ent(1, 'h020), 0);
    inval(4, 0);
    send(0, 0, va(4, 3), 2'd2, '0, 1, "R9");
    send(0, 0, va(5, 3), 2'd0, pa('h011, 3), 0, "R9");
    user_mode = 0;
    send(0, 0, va(4, 3), 2'd2, '0, 0, "R9");
    user_mode = 1;
    fill(1, 4, ent(1, 'h010), 0);
    inval(5, 1);
    send(0, 0, va(4, 3), 2'd2, '0, 1, "R9");
    send(0, 0, va(5, 3), 2'd2, '0, 1, "R9");
    send(0, 0, va(3, 7), 2'd0, pa('h033, 7), 0, "R9");

    // R10 flush empties both tables
    fill(0, 6, ent(1, 'h066), 0);
    fill(1, 7, ent(1, 'h077), 0);
    send(1, 0, va(7, 2), 2'd0, pa('h077, 2), 0, "R10");
    do_flush();
    send(1, 0, va(7, 2), 2'd2, '0, 1, "R10");
    user_mode = 0;
    send(0, 0, va(6, 2), 2'd2, '0, 0, "R10");

    // R11 lookup in the same cycle as a fill sees the old entry
    begin
      exp_t e;
      @(negedge clk);
      fill_valid = 1; fill_user = 0; fill_vpn = 9'd8; fill_entry = ent(1, 'h0AA);
      req_valid = 1; req_write = 0; req_prev = 0; req_va = va(8, 1);
      @(posedge clk);
      e.kind = 2'd2; e.pa = '0; e.wr = 0; e.usr = 0; e.tag = "R11";
      sb.push_back(e);
      @(negedge clk);
      fill_valid = 0; req_valid = 0;
    end
    send(0, 0, va(8, 1), 2'd0, pa('h0AA, 1), 0, "R11");
    // invalidate and fill on the same entry together: entry ends invalid
    @(negedge clk);
    fill_valid = 1; fill_user = 0; fill_vpn = 9'd9; fill_entry = ent(1, 'h099);
    inv_valid = 1; inv_vpn = 9'd9;
    @(negedge clk);
    fill_valid = 0; inv_valid = 0;
    send(0, 0, va(9, 0), 2'd2, '0, 0, "R11");

    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule